// File: doc/BRIEF.md
# Programmable Pixel Row Sequencer

This block steps through the rows of a 128-row pixel matrix under a small stored program. At each step it drives a 7-bit row address and a row enable to an address-decoded row driver. During the enable window it raises a gate strobe request and then a clear strobe request. A program is a list of slots. Each slot names a first row, a last row and a pass count of one to four, so a slot can revisit a band of rows several times within one frame. Slots may come in any order, which means the program can produce any row order the driver accepts.

A 128-bit skip mask marks defective rows. The sequencer steps over these rows and spends no cycles on them. The store holds several programs side by side, for example a full scan and a region-of-interest scan. A select input chooses the program, and the choice is taken up only at a frame boundary. Every stored slot carries a SECDED code. A single flipped bit is corrected on read and sets a sticky flag. A double flip stops the scan and raises a fault that holds until reset.

Programs are loaded through a plain write port. The port has an extra XOR mask that can corrupt chosen codeword bits as they are stored, so upsets can be reproduced.

Top module: `row_seq_top`

## Requirements
- R1: After synchronous reset, row_en, gate_req, clear_req, frame_done, err_corr and fault are low and the store reads as all-zero slots. No row is issued while run is low.
- R2: When run rises, slot 0 of the selected program is fetched. Slots are then taken in ascending slot order. Each slot issues its unmasked rows from the first row up to the last row in ascending order, and repeats that pass (repeat field + 1) times. The slot word is laid out as follows: bits [6:0] first row, [13:7] last row, [15:14] pass count minus one, [16] final-slot flag. The write address is {program, slot}.
- R3: A row whose bit is set in skip_mask is never addressed with row_en high and costs no cycles. Consecutive issued rows of one slot start exactly 3 cycles apart, whether or not masked rows lie between them.
- R4: Each issued row holds row_en high for two cycles with a stable address. gate_req is high in the first cycle and clear_req in the second. row_en is then low for at least one cycle before the next row.
- R5: prog_sel is sampled only when run starts a scan and when a frame completes. A change in the middle of a frame lets the current frame finish on the old program.
- R6: frame_done pulses for one cycle when the final-slot flag is seen, or when the highest slot completes.
- R7: A codeword with one flipped bit, including a check bit, yields the original slot contents and sets err_corr. err_corr stays set until reset.
- R8: A codeword with two flipped bits issues no rows. It sets fault, and fault holds with the scan halted until reset.
- R9: When run is lowered, the current frame completes and no further rows are issued.
- R10: A slot whose rows are all masked, or whose first row is above its last row, issues nothing. Such a slot costs two cycles (fetch and advance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start scanning / keep scanning after the current frame |
| prog_sel | input | PROG_W | Program to use from the next frame boundary |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | ADDR_W | Store write address {program, slot} |
| wr_data | input | 17 | Slot word to store |
| wr_flip | input | 23 | Codeword bits to invert on store (upset injection) |
| skip_mask | input | 128 | One bit per row; set means skip |
| row_addr | output | 7 | Row address to the row driver |
| row_en | output | 1 | Row driver enable |
| gate_req | output | 1 | Gate strobe request |
| clear_req | output | 1 | Clear strobe request |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| err_corr | output | 1 | Sticky corrected-error flag |
| fault | output | 1 | Uncorrectable-error fault, halts the scan |

## Verification
The bench uses the default parameters: two programs of eight slots over 128 rows. It therefore covers the top row pair 126/127, a program switch between both banks and a frame boundary set by the final-slot flag. With these sizes, one frame from each program and a repeated frame fit within a few hundred cycles. This leaves room for a table of single- and double-bit upsets on check bits, the overall parity bit and the highest data position.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;

    localparam int SEQ_ROWS = 128;
    localparam int ROW_W    = $clog2(SEQ_ROWS);
    localparam int REP_W    = 2;

    typedef struct packed {
        logic             last;
        logic [REP_W-1:0] rep;
        logic [ROW_W-1:0] hi;
        logic [ROW_W-1:0] lo;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    function automatic int check_bits(int k);
        int p;
        p = 0;
        while ((1 << p) < k + p + 1) p = p + 1;
        return p;
    endfunction

    localparam int PAR_W = check_bits(ENTRY_W);
    localparam int HPOS  = ENTRY_W + PAR_W;
    localparam int CW_W  = HPOS + 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_GATE, ST_CLR, ST_GAP, ST_NEXT, ST_HALT
    } seq_st_e;

    typedef struct packed {
        entry_t ent;
        logic   single;
        logic   dbl;
    } dec_t;

    function automatic logic is_pow2(int i);
        return (i & (i - 1)) == 0;
    endfunction

    function automatic logic [CW_W-1:0] secded_enc(logic [ENTRY_W-1:0] d);
        logic [CW_W-1:0]  cw;
        logic [PAR_W-1:0] syn;
        int               k;
        cw  = '0;
        syn = '0;
        k   = 0;
        for (int i = 1; i <= HPOS; i++) begin
            if (!is_pow2(i)) begin
                cw[i] = d[k];
                k = k + 1;
            end
        end
        for (int i = 1; i <= HPOS; i++)
            if (cw[i]) syn = syn ^ PAR_W'(i);
        for (int b = 0; b < PAR_W; b++)
            cw[1 << b] = syn[b];
        cw[0] = ^cw[HPOS:1];
        return cw;
    endfunction

    function automatic dec_t secded_dec(logic [CW_W-1:0] cw);
        logic [CW_W-1:0]    fixed;
        logic [PAR_W-1:0]   syn;
        logic [ENTRY_W-1:0] d;
        logic               ovr;
        dec_t               r;
        int                 k;
        fixed    = cw;
        syn      = '0;
        ovr      = ^cw;
        r.single = 1'b0;
        r.dbl    = 1'b0;
        for (int i = 1; i <= HPOS; i++)
            if (cw[i]) syn = syn ^ PAR_W'(i);
        if (ovr) begin
            if (syn == '0) begin
                r.single = 1'b1;
            end else if (int'(syn) <= HPOS) begin
                fixed[syn] = ~fixed[syn];
                r.single   = 1'b1;
            end else begin
                r.dbl = 1'b1;
            end
        end else if (syn != '0) begin
            r.dbl = 1'b1;
        end
        k = 0;
        d = '0;
        for (int i = 1; i <= HPOS; i++) begin
            if (!is_pow2(i)) begin
                d[k] = fixed[i];
                k = k + 1;
            end
        end
        r.ent = entry_t'(d);
        return r;
    endfunction

endpackage

// File: rtl/row_seq_store.sv
module row_seq_store
    import row_seq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0]  wr_data,
    input  logic [CW_W-1:0]     wr_flip,
    input  logic [ADDR_W-1:0]   rd_addr,
    output dec_t                rd_dec
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CW_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= secded_enc(wr_data) ^ wr_flip;
        end
    end

    always_comb rd_dec = secded_dec(mem[rd_addr]);

endmodule

// File: rtl/row_seq_find.sv
module row_seq_find
    import row_seq_pkg::*;
(
    input  logic [SEQ_ROWS-1:0] mask,
    input  logic [ROW_W:0]      lo,
    input  logic [ROW_W-1:0]    hi,
    output logic                found,
    output logic [ROW_W-1:0]    row
);
    always_comb begin
        found = 1'b0;
        row   = '0;
        for (int r = SEQ_ROWS - 1; r >= 0; r--) begin
            if ((ROW_W+1)'(r) >= lo && ROW_W'(r) <= hi && !mask[r]) begin
                found = 1'b1;
                row   = ROW_W'(r);
            end
        end
    end
endmodule

// File: rtl/row_seq_top.sv
module row_seq_top
    import row_seq_pkg::*;
#(
    parameter int N_PROG = 2,
    parameter int N_SLOT = 8,
    localparam int PROG_W = (N_PROG > 1) ? $clog2(N_PROG) : 1,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
    localparam int ADDR_W = PROG_W + SLOT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [PROG_W-1:0]   prog_sel,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0]  wr_data,
    input  logic [CW_W-1:0]     wr_flip,
    input  logic [SEQ_ROWS-1:0] skip_mask,
    output logic [ROW_W-1:0]    row_addr,
    output logic                row_en,
    output logic                gate_req,
    output logic                clear_req,
    output logic                frame_done,
    output logic                err_corr,
    output logic                fault
);
    seq_st_e            state;
    logic [PROG_W-1:0]  prog_act;
    logic [SLOT_W-1:0]  slot;
    logic [ROW_W-1:0]   cur_row;
    entry_t             ent;
    logic [REP_W-1:0]   pass;
    dec_t               rd;

    logic               first_found, next_found;
    logic [ROW_W-1:0]   first_row, next_row;
    entry_t             scan_ent;
    logic               frame_end;

    row_seq_store #(.ADDR_W(ADDR_W)) store_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_flip(wr_flip),
        .rd_addr({prog_act, slot}), .rd_dec(rd)
    );

    // first unmasked row of the slot (fresh word while fetching)
    assign scan_ent = (state == ST_FETCH) ? rd.ent : ent;

    row_seq_find first_i (
        .mask(skip_mask), .lo({1'b0, scan_ent.lo}), .hi(scan_ent.hi),
        .found(first_found), .row(first_row)
    );

    row_seq_find next_i (
        .mask(skip_mask), .lo({1'b0, cur_row} + 1'b1), .hi(ent.hi),
        .found(next_found), .row(next_row)
    );

    assign frame_end = ent.last || (slot == SLOT_W'(N_SLOT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            prog_act <= '0;
            slot     <= '0;
            cur_row  <= '0;
            ent      <= '0;
            pass     <= '0;
            err_corr <= 1'b0;
            fault    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (run) begin
                    prog_act <= prog_sel;
                    slot     <= '0;
                    state    <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (rd.dbl) begin
                        fault <= 1'b1;
                        state <= ST_HALT;
                    end else begin
                        if (rd.single) err_corr <= 1'b1;
                        ent  <= rd.ent;
                        pass <= '0;
                        if (first_found) begin
                            cur_row <= first_row;
                            state   <= ST_GATE;
                        end else begin
                            state <= ST_NEXT;
                        end
                    end
                end
                ST_GATE: state <= ST_CLR;
                ST_CLR:  state <= ST_GAP;
                ST_GAP: begin
                    if (next_found) begin
                        cur_row <= next_row;
                        state   <= ST_GATE;
                    end else if (pass != ent.rep) begin
                        pass    <= pass + 1'b1;
                        cur_row <= first_row;
                        state   <= ST_GATE;
                    end else begin
                        state <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (frame_end) begin
                        slot     <= '0;
                        prog_act <= prog_sel;
                        state    <= run ? ST_FETCH : ST_IDLE;
                    end else begin
                        slot  <= slot + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                ST_HALT: state <= ST_HALT;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign row_addr   = cur_row;
    assign row_en     = (state == ST_GATE) || (state == ST_CLR);
    assign gate_req   = (state == ST_GATE);
    assign clear_req  = (state == ST_CLR);
    assign frame_done = (state == ST_NEXT) && frame_end;

endmodule

// File: rtl/row_seq_chk.sv
module row_seq_chk
    import row_seq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ROW_W-1:0]    row_addr,
    input logic                row_en,
    input logic                gate_req,
    input logic                clear_req,
    input logic                frame_done,
    input logic                err_corr,
    input logic                fault,
    input logic [SEQ_ROWS-1:0] skip_mask
);
    assert_gate_then_clear_R4: assert property (@(posedge clk) disable iff (rst)
        gate_req |=> clear_req && row_en && (row_addr == $past(row_addr)));

    assert_gap_after_row_R4: assert property (@(posedge clk) disable iff (rst)
        clear_req |=> !row_en);

    assert_gate_inside_en_R4: assert property (@(posedge clk) disable iff (rst)
        gate_req |-> row_en && !clear_req);

    assert_no_masked_row_R3: assert property (@(posedge clk) disable iff (rst)
        row_en |-> !skip_mask[row_addr]);

    assert_frame_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err_corr |=> err_corr);

    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> !row_en && !frame_done);
endmodule

bind row_seq_top row_seq_chk chk_i (
    .clk(clk), .rst(rst), .row_addr(row_addr), .row_en(row_en),
    .gate_req(gate_req), .clear_req(clear_req), .frame_done(frame_done),
    .err_corr(err_corr), .fault(fault), .skip_mask(skip_mask)
);

// File: tb/row_seq_top_tb_top.sv
module row_seq_top_tb_top;
    import row_seq_pkg::*;

    localparam int N_PROG = 2;
    localparam int N_SLOT = 8;
    localparam int PROG_W = 1;
    localparam int ADDR_W = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                run = 1'b0;
    logic [PROG_W-1:0]   prog_sel = '0;
    logic                wr_en = 1'b0;
    logic [ADDR_W-1:0]   wr_addr = '0;
    logic [ENTRY_W-1:0]  wr_data = '0;
    logic [CW_W-1:0]     wr_flip = '0;
    logic [SEQ_ROWS-1:0] skip_mask = '0;
    logic [ROW_W-1:0]    row_addr;
    logic                row_en, gate_req, clear_req, frame_done, err_corr, fault;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    row_seq_top #(.N_PROG(N_PROG), .N_SLOT(N_SLOT)) dut_i (
        .clk(clk), .rst(rst), .run(run), .prog_sel(prog_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_flip(wr_flip),
        .skip_mask(skip_mask), .row_addr(row_addr), .row_en(row_en),
        .gate_req(gate_req), .clear_req(clear_req), .frame_done(frame_done),
        .err_corr(err_corr), .fault(fault)
    );

    // monitor: record issued rows, their cycle, frames and protocol breaks
    int rec   [64];
    int rec_t [64];
    int nrec, nframe, viol, cyc;
    logic prev_en, prev_gate;
    logic [ROW_W-1:0] prev_addr;

    always @(negedge clk) begin
        if (rst) begin
            nrec = 0; nframe = 0; viol = 0; cyc = 0;
            prev_en = 1'b0; prev_gate = 1'b0; prev_addr = '0;
        end else begin
            cyc = cyc + 1;
            if (gate_req && prev_en) viol = viol + 1;
            if (clear_req && !(prev_gate && row_addr == prev_addr)) viol = viol + 1;
            if (row_en && skip_mask[row_addr]) viol = viol + 1;
            if (gate_req && nrec < 64) begin
                rec[nrec]   = int'(row_addr);
                rec_t[nrec] = cyc;
                nrec = nrec + 1;
            end
            if (frame_done) nframe = nframe + 1;
            prev_en = row_en; prev_gate = gate_req; prev_addr = row_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; run = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put_slot(input int prog, input int slot, input int lo, input int hi,
                            input int passes, input bit last, input logic [CW_W-1:0] flip);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'((prog << 3) | slot);
        wr_data = {last, REP_W'(passes - 1), ROW_W'(hi), ROW_W'(lo)};
        wr_flip = flip;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_flip = '0;
    endtask

    task automatic wait_rows(input int n);
        for (int i = 0; i < 2000 && nrec < n; i++) @(negedge clk);
    endtask

    // upset table: [22:0] codeword flip mask, [23] err_corr expected, [24] fault expected
    localparam logic [24:0] UPSET_VEC [7] = '{
        {2'b00, 23'h000000},
        {2'b01, 23'h000001},
        {2'b01, 23'h000002},
        {2'b01, 23'h000008},
        {2'b01, 23'h400000},
        {2'b10, 23'h000028},
        {2'b10, 23'h000081}
    };

    localparam int EXP_ROWS [22] = '{0,1,3,5,6,5,6,5,6,127,
                                     90,20,21,20,21,50,90,20,21,20,21,50};

    initial begin
        #(4 * 150000);
        errors = errors + 1;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        int n_at_end;
        do_reset();

        // R1: reset state and idle while run is low
        chk(!row_en && !gate_req && !clear_req && !frame_done, "R1 strobes", row_en, 0);
        chk(!err_corr && !fault, "R1 flags", fault, 0);
        repeat (20) @(negedge clk);
        chk(nrec == 0, "R1 idle rows", nrec, 0);

        skip_mask = '0;
        skip_mask[2] = 1'b1; skip_mask[60] = 1'b1;
        skip_mask[61] = 1'b1; skip_mask[126] = 1'b1;
        put_slot(0, 0, 0, 3, 1, 0, '0);
        put_slot(0, 1, 5, 6, 3, 0, '0);
        put_slot(0, 2, 60, 61, 1, 0, '0);
        put_slot(0, 3, 30, 20, 2, 0, '0);
        put_slot(0, 4, 126, 127, 1, 1, '0);
        put_slot(1, 0, 90, 90, 1, 0, '0);
        put_slot(1, 1, 20, 21, 2, 0, '0);
        put_slot(1, 2, 50, 50, 1, 1, '0);

        prog_sel = 1'b0;
        run = 1'b1;
        wait_rows(4);
        prog_sel = 1'b1;   // R5: mid-frame change
        wait_rows(22);

        bad = 0;
        for (int i = 0; i < 10; i++) if (rec[i] != EXP_ROWS[i]) bad = bad + 1;
        chk(bad == 0, "R2 row order prog0", bad, 0);
        bad = 0;
        for (int i = 10; i < 22; i++) if (rec[i] != EXP_ROWS[i]) bad = bad + 1;
        chk(bad == 0, "R5 switch at frame boundary", bad, 0);
        chk(rec[9] == 127, "R5 old frame completed", rec[9], 127);
        chk(rec_t[2] - rec_t[1] == 3, "R3 masked row zero cycles", rec_t[2] - rec_t[1], 3);
        chk(rec_t[5] - rec_t[4] == 3, "R2 repeat pass pitch", rec_t[5] - rec_t[4], 3);
        chk(rec_t[9] - rec_t[8] == 9, "R10 empty slots cost", rec_t[9] - rec_t[8], 9);
        chk(nframe == 2, "R6 frame pulses", nframe, 2);
        chk(viol == 0, "R4 R3 row protocol", viol, 0);

        // R9: drop run, current frame ends, then nothing more
        run = 1'b0;
        for (int i = 0; i < 200 && !frame_done; i++) @(negedge clk);
        n_at_end = nrec;
        repeat (40) @(negedge clk);
        chk(nrec == n_at_end, "R9 stop after frame", nrec, n_at_end);
        chk(rec[nrec-1] == 50, "R9 frame finished", rec[nrec-1], 50);
        chk(!row_en, "R9 enable low", row_en, 0);

        // R7 / R8 upset table
        foreach (UPSET_VEC[v]) begin
            do_reset();
            skip_mask = '0;
            put_slot(0, 0, 10, 11, 1, 1, UPSET_VEC[v][22:0]);
            prog_sel = 1'b0;
            run = 1'b1;
            repeat (40) @(negedge clk);
            if (UPSET_VEC[v][24]) begin
                chk(fault == 1'b1, "R8 double error fault", fault, 1);
                chk(nrec == 0, "R8 no rows issued", nrec, 0);
            end else begin
                chk(nrec >= 2 && rec[0] == 10 && rec[1] == 11, "R7 corrected slot rows", rec[0], 10);
                chk(err_corr == UPSET_VEC[v][23], "R7 error flag", err_corr, int'(UPSET_VEC[v][23]));
                chk(fault == 1'b0, "R7 no fault", fault, 0);
            end
        end

        // R8: fault holds through run toggling, clears only at reset
        run = 1'b0;
        repeat (10) @(negedge clk);
        run = 1'b1;
        repeat (10) @(negedge clk);
        chk(fault == 1'b1 && nrec == 0, "R8 fault persists", fault, 1);
        do_reset();
        chk(fault == 1'b0 && err_corr == 1'b0, "R1 R8 reset clears", fault, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule